// File: doc/BRIEF.md
# Eight-Slot TDM Serial Link Port

This block connects one node to a shared time-division multiplexed serial link. A frame is made of eight slots of sixteen bit times each, 128 bit clocks in total. Two serial lines run side by side. One carries the data word of the slot. The other carries an 8-bit destination field, which occupies the first eight bit times of the slot and is followed by eight zero bits. The block's clock is the serial bit clock, so one bit moves per cycle.

The node owns exactly one slot, chosen by `own_slot`, and drives the shared lines only during that slot. An 8-bit mask selects which slots it captures. A frame-sync pulse marks the frame boundary. In master mode the block generates the pulse. In slave mode it follows an external pulse and realigns to it.

Both directions have two stages. Transmit words enter through a valid/ready port into a holding register, and at the start of the owned slot the holding register moves into the shifter. A word is accepted on any cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while the holding register is occupied. A producer that sees `tx_ready` low must keep `tx_valid` and its data unchanged. Received words go into a holding register that is presented on a valid/ready port. The serial link cannot be stalled, so back-pressure on `rx_ready` is absorbed only by that one register. A word that arrives while the register is still unread replaces the old word and raises an overrun flag.

Top module: `tdm_link_port`

## Requirements
- R1: In master mode (`sync_master`=1), `sync_out` is high for exactly one cycle in every 128, during bit 15 of slot 7. The next cycle is bit 0 of slot 0. In slave mode `sync_out` stays low. After reset the first cycle is bit 0 of slot 0.
- R2: In slave mode, a high `sync_in` sampled at a clock edge makes the following cycle bit 0 of slot 0, from any position in the frame. In master mode `sync_in` has no effect.
- R3: For the 16 cycles of the owned slot, `tdm_oe` is high and `tdm_dat_o` sends the word MSB first. In every other cycle `tdm_oe` and `tdm_dat_o` are low. The owned slot is the one that `own_slot` names at the clock edge that enters the slot.
- R4: During the owned slot, `tdm_adr_o` sends `tx_dest` MSB first in bit times 0 to 7 and is low in bit times 8 to 15. Outside the owned slot it is low.
- R5: `tx_ready` is high exactly when the transmit holding register is empty. A word moves from the holding register into the shifter at the edge that enters the owned slot. This lets one word wait while another is being sent.
- R6: If the holding register is empty when the owned slot starts, the slot sends 16 zero bits on both lines with `tdm_oe` high, and `tx_underrun` is set. The flag stays set until a `flag_clr` cycle in which no new underrun occurs.
- R7: A slot s is captured only if `rx_slot_mask[s]` is 1 when its bit 15 is sampled. The captured word is the 16 bits of `tdm_dat_i` taken MSB first. `rx_dest` holds the first 8 bits of `tdm_adr_i` in that slot, and `rx_slot` holds s.
- R8: `rx_valid` goes high in the cycle after the edge that samples bit 15 of a captured slot. It stays high, with the data unchanged, until a cycle in which `rx_ready` is high.
- R9: If a slot is captured while `rx_valid` is high and `rx_ready` is low, the newer word replaces the older one and `rx_overrun` is set. The flag stays set until a `flag_clr` cycle in which no new overrun occurs. Taking the old word and capturing a new one in the same cycle is not an overrun.
- R10: While `rst_n` is low, `tx_ready` is 1, and `rx_valid`, `tdm_oe`, `tx_underrun`, `rx_overrun` and `sync_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_master | input | 1 | 1: generate frame sync, 0: follow `sync_in` |
| sync_in | input | 1 | External frame-sync pulse (slave mode) |
| sync_out | output | 1 | Generated frame-sync pulse (master mode) |
| own_slot | input | 3 | Slot this node transmits in |
| rx_slot_mask | input | 8 | One bit per slot to capture |
| flag_clr | input | 1 | Clears the sticky underrun and overrun flags |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 16 | Transmit data word |
| tx_dest | input | 8 | Transmit destination field |
| tdm_dat_o | output | 1 | Serial data line out |
| tdm_adr_o | output | 1 | Serial address line out |
| tdm_oe | output | 1 | Drive enable for both outgoing lines |
| tdm_dat_i | input | 1 | Serial data line in |
| tdm_adr_i | input | 1 | Serial address line in |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received data word |
| rx_dest | output | 8 | Received destination field |
| rx_slot | output | 3 | Slot the word came from |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The hardest conditions to reach from the ports are a receive overrun that happens while the consumer is stalling, and a slave realignment that lands in the middle of a slot while the node is transmitting or capturing. The bench reaches the overrun by holding `rx_ready` low for whole frames with every slot enabled. It forces the realignment by sending one extra `sync_in` pulse at an odd frame position in slave mode. It also pushes the owned slot to 0 and 7, so that the shifter load crosses the frame wrap, and it withholds transmit words to cause underruns. Around these directed phases, random traffic, masks and stalls are checked every cycle against a model in the bench.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
  // Slot count and word width must be powers of two; the position counter
  // is split into slot and bit fields.
  parameter int unsigned SLOTS  = 8;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned ADDR_W = 8;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned SLOTS  = tdm_link_pkg::SLOTS,
  parameter int unsigned WORD_W = tdm_link_pkg::WORD_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned POS_W  = SLOT_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              sync_in,
  output logic              sync_out,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitn,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit
);
  logic [POS_W-1:0] pos, pos_nxt;

  always_comb begin
    if (!master && sync_in) pos_nxt = '0;
    else                    pos_nxt = pos + 1'b1;   // wraps at frame end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end

  assign slot     = pos[POS_W-1:BIT_W];
  assign bitn     = pos[BIT_W-1:0];
  assign nxt_slot = pos_nxt[POS_W-1:BIT_W];
  assign nxt_bit  = pos_nxt[BIT_W-1:0];
  assign sync_out = master && (&pos);

  // R1: a generated pulse is followed by the first bit of slot 0
  a_r1_sync_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> (slot == '0 && bitn == '0));
  // R1: pulse lasts a single cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);
  // R2: slave realignment
  a_r2_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && sync_in) |=> (slot == '0 && bitn == '0));
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
  parameter int unsigned SLOTS  = tdm_link_pkg::SLOTS,
  parameter int unsigned WORD_W = tdm_link_pkg::WORD_W,
  parameter int unsigned ADDR_W = tdm_link_pkg::ADDR_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned PAD    = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] own_slot,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] nxt_slot,
  input  logic [BIT_W-1:0]  nxt_bit,
  input  logic              flag_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_dest,
  output logic              line_dat,
  output logic              line_adr,
  output logic              line_oe,
  output logic              underrun
);
  logic              hold_full;
  logic [WORD_W-1:0] hold_d;
  logic [ADDR_W-1:0] hold_a;
  logic [WORD_W-1:0] sh_d, sh_a;
  logic              live;
  logic [SLOT_W-1:0] own_q;
  logic              load, accept;

  assign load     = (nxt_slot == own_slot) && (nxt_bit == '0);
  assign accept   = in_valid && !hold_full;
  assign in_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_d    <= '0;
      hold_a    <= '0;
    end else if (load && hold_full) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_d    <= in_data;
      hold_a    <= in_dest;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_d  <= '0;
      sh_a  <= '0;
      live  <= 1'b0;
      own_q <= '0;
    end else if (load) begin
      live  <= 1'b1;
      own_q <= own_slot;
      sh_d  <= hold_full ? hold_d : '0;
      sh_a  <= hold_full ? (WORD_W'(hold_a) << PAD) : '0;
    end else begin
      sh_d <= {sh_d[WORD_W-2:0], 1'b0};
      sh_a <= {sh_a[WORD_W-2:0], 1'b0};
      if (nxt_bit == '0) live <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 underrun <= 1'b0;
    else if (load && !hold_full) underrun <= 1'b1;
    else if (flag_clr)          underrun <= 1'b0;
  end

  assign line_oe  = live;
  assign line_dat = live & sh_d[WORD_W-1];
  assign line_adr = live & sh_a[WORD_W-1];

  // R3: the lines are driven only inside the slot latched at load
  a_r3_oe_in_owned: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> (slot == own_q));
  // R5: a waiting word is not dropped before its slot comes
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> hold_full);
  // R6: an empty start sends zeros with the lines enabled
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold_full) |=> (line_oe && !line_dat && !line_adr && underrun));
  // R6: flag is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !flag_clr) |=> underrun);
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
  parameter int unsigned SLOTS  = tdm_link_pkg::SLOTS,
  parameter int unsigned WORD_W = tdm_link_pkg::WORD_W,
  parameter int unsigned ADDR_W = tdm_link_pkg::ADDR_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bitn,
  input  logic [SLOTS-1:0]  mask,
  input  logic              flag_clr,
  input  logic              line_dat,
  input  logic              line_adr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [ADDR_W-1:0] out_dest,
  output logic [SLOT_W-1:0] out_slot,
  output logic              overrun
);
  logic [WORD_W-2:0] sh_d;
  logic [ADDR_W-2:0] sh_a;
  logic [ADDR_W-1:0] a_cap;
  logic              done, pop;

  assign done = (bitn == BIT_W'(WORD_W-1)) && mask[slot];
  assign pop  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_d  <= '0;
      sh_a  <= '0;
      a_cap <= '0;
    end else begin
      sh_d <= {sh_d[WORD_W-3:0], line_dat};
      sh_a <= {sh_a[ADDR_W-3:0], line_adr};
      if (bitn == BIT_W'(ADDR_W-1)) a_cap <= {sh_a, line_adr};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dest  <= '0;
      out_slot  <= '0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_data  <= {sh_d, line_dat};
      out_dest  <= a_cap;
      out_slot  <= slot;
    end else if (pop) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             overrun <= 1'b0;
    else if (done && out_valid && !out_ready) overrun <= 1'b1;
    else if (flag_clr)                      overrun <= 1'b0;
  end

  // R8: a stalled word stays put
  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !done) |=> (out_valid && $stable(out_data) && $stable(out_slot)));
  // R7: nothing appears without a captured slot
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !done) |=> !out_valid);
  // R9: overrun flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flag_clr) |=> overrun);
endmodule

// File: rtl/tdm_link_port.sv
module tdm_link_port #(
  parameter int unsigned SLOTS  = tdm_link_pkg::SLOTS,
  parameter int unsigned WORD_W = tdm_link_pkg::WORD_W,
  parameter int unsigned ADDR_W = tdm_link_pkg::ADDR_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_master,
  input  logic              sync_in,
  output logic              sync_out,
  input  logic [SLOT_W-1:0] own_slot,
  input  logic [SLOTS-1:0]  rx_slot_mask,
  input  logic              flag_clr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  input  logic [ADDR_W-1:0] tx_dest,
  output logic              tdm_dat_o,
  output logic              tdm_adr_o,
  output logic              tdm_oe,
  input  logic              tdm_dat_i,
  input  logic              tdm_adr_i,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic [ADDR_W-1:0] rx_dest,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              tx_underrun,
  output logic              rx_overrun
);
  logic [SLOT_W-1:0] slot, nxt_slot;
  logic [BIT_W-1:0]  bitn, nxt_bit;

  tdm_frame_timer #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .master(sync_master), .sync_in(sync_in),
    .sync_out(sync_out), .slot(slot), .bitn(bitn),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit)
  );

  tdm_tx_path #(.SLOTS(SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .own_slot(own_slot), .slot(slot),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .flag_clr(flag_clr),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data), .in_dest(tx_dest),
    .line_dat(tdm_dat_o), .line_adr(tdm_adr_o), .line_oe(tdm_oe),
    .underrun(tx_underrun)
  );

  tdm_rx_path #(.SLOTS(SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .bitn(bitn), .mask(rx_slot_mask),
    .flag_clr(flag_clr), .line_dat(tdm_dat_i), .line_adr(tdm_adr_i),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .out_dest(rx_dest), .out_slot(rx_slot), .overrun(rx_overrun)
  );
endmodule

// File: tb/tdm_link_port_bench.sv
module tdm_link_port_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_master = 1'b1, sync_in = 1'b0, flag_clr = 1'b0;
  logic [2:0] own_slot = 3'd2;
  logic [7:0] rx_slot_mask = 8'hA5;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic [15:0] tx_data = '0;
  logic [7:0] tx_dest = '0;
  logic tdm_dat_i = 1'b0, tdm_adr_i = 1'b0;
  logic sync_out, tx_ready, tdm_dat_o, tdm_adr_o, tdm_oe, rx_valid;
  logic [15:0] rx_data;
  logic [7:0] rx_dest;
  logic [2:0] rx_slot;
  logic tx_underrun, rx_overrun;

  always #(CLK_P/2) clk = ~clk;

  tdm_link_port u_tdm_link_port (
    .clk(clk), .rst_n(rst_n), .sync_master(sync_master), .sync_in(sync_in),
    .sync_out(sync_out), .own_slot(own_slot), .rx_slot_mask(rx_slot_mask),
    .flag_clr(flag_clr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_dest(tx_dest), .tdm_dat_o(tdm_dat_o),
    .tdm_adr_o(tdm_adr_o), .tdm_oe(tdm_oe), .tdm_dat_i(tdm_dat_i),
    .tdm_adr_i(tdm_adr_i), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_dest(rx_dest), .rx_slot(rx_slot),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  int n_chk = 0, n_bad = 0;
  bit chk_en = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [6:0]  m_pos;
  logic        m_hf, m_live, m_urun, m_acc;
  logic [15:0] m_hd, m_cd, m_ca;
  logic [7:0]  m_ha;
  logic        m_rxv, m_ovr;
  logic [15:0] m_rxd;
  logic [7:0]  m_rxa;
  logic [2:0]  m_rxs;
  logic [15:0] fr_d [8];
  logic [7:0]  fr_a [8];
  logic [6:0]  npos;
  logic        ld, acc, cap;

  function automatic logic [15:0] dest_word(logic [7:0] d);
    return {d, 8'h00};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos <= '0; m_hf <= 0; m_live <= 0; m_urun <= 0; m_acc <= 0;
      m_hd <= '0; m_ha <= '0; m_cd <= '0; m_ca <= '0;
      m_rxv <= 0; m_ovr <= 0; m_rxd <= '0; m_rxa <= '0; m_rxs <= '0;
    end else begin
      npos = (!sync_master && sync_in) ? 7'd0 : m_pos + 7'd1;
      ld   = (npos == {own_slot, 4'd0});
      acc  = tx_valid && !m_hf;
      cap  = (m_pos[3:0] == 4'd15) && rx_slot_mask[m_pos[6:4]];
      m_pos <= npos;
      m_acc <= acc;
      // transmit side
      if (ld) begin
        m_live <= 1'b1;
        m_cd   <= m_hf ? m_hd : 16'h0;
        m_ca   <= m_hf ? dest_word(m_ha) : 16'h0;
      end else begin
        m_cd <= m_cd << 1;
        m_ca <= m_ca << 1;
        if (npos[3:0] == 4'd0) m_live <= 1'b0;
      end
      if (ld && m_hf) m_hf <= 1'b0;
      else if (acc) begin m_hf <= 1'b1; m_hd <= tx_data; m_ha <= tx_dest; end
      if (ld && !m_hf) m_urun <= 1'b1;
      else if (flag_clr) m_urun <= 1'b0;
      // receive side
      if (cap) begin
        m_rxv <= 1'b1;
        m_rxd <= fr_d[m_pos[6:4]];
        m_rxa <= fr_a[m_pos[6:4]];
        m_rxs <= m_pos[6:4];
      end else if (m_rxv && rx_ready) m_rxv <= 1'b0;
      if (cap && m_rxv && !rx_ready) m_ovr <= 1'b1;
      else if (flag_clr) m_ovr <= 1'b0;
    end
  end

  // ---------------- per-cycle checks ----------------
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk("R1", "sync_out", sync_out, sync_master && (m_pos == 7'd127));
      chk("R3", "tdm_oe", tdm_oe, m_live);
      chk("R3", "tdm_dat_o", tdm_dat_o, m_live & m_cd[15]);
      chk("R4", "tdm_adr_o", tdm_adr_o, m_live & m_ca[15]);
      chk("R5", "tx_ready", tx_ready, !m_hf);
      chk("R6", "tx_underrun", tx_underrun, m_urun);
      chk("R8", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) begin
        chk("R7", "rx_data", rx_data, m_rxd);
        chk("R7", "rx_dest", rx_dest, m_rxa);
        chk("R7", "rx_slot", rx_slot, m_rxs);
      end
      chk("R9", "rx_overrun", rx_overrun, m_ovr);
    end
  end

  // ---------------- stimulus ----------------
  int tx_rate, rdy_rate, clr_rate, early_at;
  bit rand_cfg;

  task automatic step();
    @(posedge clk);
    #1;
    if (!tx_valid || m_acc) begin
      tx_valid = (($urandom % 100) < tx_rate);
      tx_data  = 16'($urandom);
      tx_dest  = 8'($urandom);
    end
    rx_ready = (($urandom % 100) < rdy_rate);
    flag_clr = (($urandom % 100) < clr_rate);
    if (sync_master) sync_in = (($urandom % 20) == 0);   // R2: ignored in master mode
    else begin
      sync_in = (m_pos == 7'd127) || (early_at >= 0 && m_pos == 7'(early_at));
      if (early_at >= 0 && m_pos == 7'(early_at)) early_at = -1;
    end
    if (m_pos == 7'd0) begin
      for (int i = 0; i < 8; i++) begin
        fr_d[i] = 16'($urandom);
        fr_a[i] = 8'($urandom);
      end
      if (rand_cfg) begin
        own_slot     = 3'($urandom);
        rx_slot_mask = 8'($urandom);
      end
    end
    tdm_dat_i = fr_d[m_pos[6:4]][4'd15 - m_pos[3:0]];
    tdm_adr_i = (m_pos[3:0] < 4'd8) ? fr_a[m_pos[6:4]][3'd7 - m_pos[2:0]] : 1'b0;
  endtask

  task automatic run(int frames);
    repeat (frames * 128) step();
  endtask

  bit done = 1'b0;

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) begin fr_d[i] = '0; fr_a[i] = '0; end
    early_at = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "tx_ready", tx_ready, 1);
    chk("R10", "rx_valid", rx_valid, 0);
    chk("R10", "tdm_oe", tdm_oe, 0);
    chk("R10", "tx_underrun", tx_underrun, 0);
    chk("R10", "rx_overrun", rx_overrun, 0);
    chk("R10", "sync_out", sync_out, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk_en = 1'b1;
    // random master traffic, R2 noise on sync_in
    tx_rate = 85; rdy_rate = 90; clr_rate = 3; rand_cfg = 1; run(6);
    // R6: no words offered, owned slot at the frame wrap (slot 0)
    rand_cfg = 0; own_slot = 3'd0; tx_rate = 0; clr_rate = 0; run(2);
    clr_rate = 100; run(1);
    // R5: continuous supply, last slot
    own_slot = 3'd7; tx_rate = 100; clr_rate = 0; run(2);
    // R9 and R8: all slots captured, consumer stalled
    rx_slot_mask = 8'hFF; rdy_rate = 0; run(2);
    rdy_rate = 50; clr_rate = 5; run(1);
    // R2: slave mode with an early realignment inside a slot
    sync_master = 1'b0; rdy_rate = 80; tx_rate = 70; rand_cfg = 1; run(2);
    early_at = 50; own_slot = 3'd3; rand_cfg = 0; run(2);
    rand_cfg = 1; run(2);
    sync_master = 1'b1; run(4);
    chk_en = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule